// File: doc/BRIEF.md
# Temperature Event Output Controller

This block decides when a thermal monitor pulls its shared, active-low event wire. A temperature sampler supplies a signed reading every cycle, and the register file supplies an upper and a lower window limit, a critical limit, a hysteresis amount for the critical limit, a mode code and an output enable. When the host writes 1 to the clear bit, a one-cycle clear strobe arrives. The block produces a drive-low enable for an open-drain pad, where 1 means the pad pulls the wire low. It also produces three status flags that show where the reading lies relative to the limits.

There are three modes. In the latched-interrupt mode the event is held after the reading leaves the window, until the host clears it. In the comparator mode the event follows the window condition. In the critical-only mode the window limits are ignored. The critical limit is always evaluated like a comparator, with hysteresis on release, and it is folded into the event in every mode. All outputs are registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `tev_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high, all outputs become 0 on the next edge. The latch, crossing-history and critical-hold state are cleared.
- R2: One edge after the inputs are sampled, the status flags show three signed comparisons: reading above the upper limit, reading below the lower limit, and reading above the critical limit. The flags do not depend on mode or enable.
- R3: Mode code 1 (comparator) drives the event exactly while the reading is above the upper limit or below the lower limit, or while the critical hold is set.
- R4: Mode code 0 (latched interrupt) sets the event latch when the window condition goes from false to true. The latch then holds without any clear strobe, even after the reading returns inside the window.
- R5: In mode 0, a clear strobe releases the latch even if the window condition still holds. The latch sets again only on a new false-to-true transition of the condition. A transition that coincides with a clear still sets the latch.
- R6: The critical hold sets when the reading is above the critical limit. It releases only when the reading is strictly below the critical limit minus the hysteresis, and holds in between. It is active in every mode, ORed into the event, and a clear strobe has no effect on it.
- R7: Mode code 2 (critical-only) ignores the upper and lower limits. The event is driven only by the critical hold.
- R8: With the output enable at 0, the drive output is 0, while the status flags and all internal event state keep updating. Enabling the output again shows the current event state on the next edge.
- R9: Readings and limits are 13-bit two's-complement values in 1/16 degree units, compared as signed numbers. The hysteresis is an unsigned amount, and the release threshold is computed one bit wider so that it cannot wrap.
- R10: Mode code 3 behaves exactly like mode code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| temp_i | input | TEMP_W | Current reading, signed |
| upper_lim_i | input | TEMP_W | Upper window limit, signed |
| lower_lim_i | input | TEMP_W | Lower window limit, signed |
| crit_lim_i | input | TEMP_W | Critical limit, signed |
| crit_hyst_i | input | HYST_W | Critical release hysteresis, unsigned |
| mode_i | input | 2 | 0 latched, 1 comparator, 2 critical-only, 3 as 1 |
| event_en_i | input | 1 | Event output enable |
| clear_evt_i | input | 1 | One-cycle strobe that clears the latched event |
| event_drive_o | output | 1 | 1 = pull the open-drain event wire low |
| flag_above_upper_o | output | 1 | Reading above upper limit |
| flag_below_lower_o | output | 1 | Reading below lower limit |
| flag_above_crit_o | output | 1 | Reading above critical limit |

## Verification
Several properties are checked on every cycle:
- The status flags follow the signed comparisons with a one-edge delay.
- A reading above the critical limit with the output enabled always produces a drive.
- The comparator modes drive whenever the window condition held.
- The critical-only drive never appears once the reading is below the release threshold.
- The drive never appears while the output is disabled.
- An uncleared latch persists.

Only the bench scenarios can show the history-dependent behaviour. This includes the hysteresis band, where the outcome depends on the direction of approach. It also includes the rule that a latch cleared while the condition holds stays released until the reading leaves and re-enters the condition, and the behaviour across mode switches during a walk of the reading.

// File: rtl/tev_pkg.sv
package tev_pkg;

    localparam int TEV_TEMP_W = 13;
    localparam int TEV_HYST_W = 8;

    typedef enum logic [1:0] {
        TEV_LATCHED   = 2'd0,
        TEV_FOLLOW    = 2'd1,
        TEV_CRIT_ONLY = 2'd2,
        TEV_FOLLOW_B  = 2'd3
    } tev_mode_e;

    typedef struct packed {
        logic over_hi;
        logic under_lo;
        logic over_crit;
        logic under_release;
    } tev_cmp_t;

    function automatic logic window_hit(input tev_cmp_t c);
        return c.over_hi | c.under_lo;
    endfunction

    function automatic logic mode_follows(input tev_mode_e m);
        return (m == TEV_FOLLOW) || (m == TEV_FOLLOW_B);
    endfunction

endpackage

// File: rtl/tev_compare.sv
module tev_compare
    import tev_pkg::*;
#(
    parameter int TEMP_W = TEV_TEMP_W,
    parameter int HYST_W = TEV_HYST_W
) (
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] hi_i,
    input  logic [TEMP_W-1:0] lo_i,
    input  logic [TEMP_W-1:0] crit_i,
    input  logic [HYST_W-1:0] hyst_i,
    output tev_cmp_t          cmp_o
);
    localparam int EXT_W = TEMP_W + 1;

    logic signed [EXT_W-1:0] temp_x;
    logic signed [EXT_W-1:0] crit_x;
    logic signed [EXT_W-1:0] hyst_x;
    logic signed [EXT_W-1:0] release_x;

    // Sign-extend to one extra bit so crit - hyst cannot wrap.
    assign temp_x    = $signed({temp_i[TEMP_W-1], temp_i});
    assign crit_x    = $signed({crit_i[TEMP_W-1], crit_i});
    assign hyst_x    = $signed({{(EXT_W-HYST_W){1'b0}}, hyst_i});
    assign release_x = crit_x - hyst_x;

    always_comb begin
        cmp_o.over_hi       = $signed(temp_i) > $signed(hi_i);
        cmp_o.under_lo      = $signed(temp_i) < $signed(lo_i);
        cmp_o.over_crit     = $signed(temp_i) > $signed(crit_i);
        cmp_o.under_release = temp_x < release_x;
    end

endmodule

// File: rtl/tev_crit_track.sv
module tev_crit_track (
    input  logic clk_i,
    input  logic rst_i,
    input  logic over_crit_i,
    input  logic under_release_i,
    output logic hold_d_o
);
    logic hold_q;

    always_comb begin
        hold_d_o = hold_q;
        if (over_crit_i) begin
            hold_d_o = 1'b1;
        end else if (under_release_i) begin
            hold_d_o = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d_o;
        end
    end

endmodule

// File: rtl/tev_window_track.sv
module tev_window_track
    import tev_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  tev_mode_e mode_i,
    input  logic      cond_i,
    input  logic      clear_i,
    output logic      win_d_o,
    output logic      latch_q_o
);
    logic latch_q;
    logic latch_d;
    logic prev_q;
    logic rise;

    assign rise = cond_i & ~prev_q;

    always_comb begin
        latch_d = 1'b0;
        win_d_o = 1'b0;
        unique case (mode_i)
            TEV_LATCHED: begin
                latch_d = rise | (latch_q & ~clear_i);
                win_d_o = latch_d;
            end
            TEV_CRIT_ONLY: begin
                latch_d = 1'b0;
                win_d_o = 1'b0;
            end
            default: begin
                latch_d = 1'b0;
                win_d_o = mode_follows(mode_i) & cond_i;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            latch_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            latch_q <= latch_d;
            prev_q  <= cond_i;
        end
    end

    assign latch_q_o = latch_q;

endmodule

// File: rtl/tev_ctrl.sv
module tev_ctrl
    import tev_pkg::*;
#(
    parameter int TEMP_W = TEV_TEMP_W,
    parameter int HYST_W = TEV_HYST_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] upper_lim_i,
    input  logic [TEMP_W-1:0] lower_lim_i,
    input  logic [TEMP_W-1:0] crit_lim_i,
    input  logic [HYST_W-1:0] crit_hyst_i,
    input  logic [1:0]        mode_i,
    input  logic              event_en_i,
    input  logic              clear_evt_i,
    output logic              event_drive_o,
    output logic              flag_above_upper_o,
    output logic              flag_below_lower_o,
    output logic              flag_above_crit_o
);
    tev_cmp_t  cmp;
    tev_mode_e mode_e;
    logic      crit_d;
    logic      win_d;
    logic      win_latch;
    logic      evt_d;

    assign mode_e = tev_mode_e'(mode_i);

    tev_compare #(.TEMP_W(TEMP_W), .HYST_W(HYST_W)) u_cmp (
        .temp_i (temp_i),
        .hi_i   (upper_lim_i),
        .lo_i   (lower_lim_i),
        .crit_i (crit_lim_i),
        .hyst_i (crit_hyst_i),
        .cmp_o  (cmp)
    );

    tev_crit_track u_crit (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .over_crit_i     (cmp.over_crit),
        .under_release_i (cmp.under_release),
        .hold_d_o        (crit_d)
    );

    tev_window_track u_win (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mode_i    (mode_e),
        .cond_i    (window_hit(cmp)),
        .clear_i   (clear_evt_i),
        .win_d_o   (win_d),
        .latch_q_o (win_latch)
    );

    assign evt_d = win_d | crit_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            event_drive_o      <= 1'b0;
            flag_above_upper_o <= 1'b0;
            flag_below_lower_o <= 1'b0;
            flag_above_crit_o  <= 1'b0;
        end else begin
            event_drive_o      <= event_en_i & evt_d;
            flag_above_upper_o <= cmp.over_hi;
            flag_below_lower_o <= cmp.under_lo;
            flag_above_crit_o  <= cmp.over_crit;
        end
    end

endmodule

// File: rtl/tev_ctrl_chk.sv
module tev_ctrl_chk #(
    parameter int TEMP_W = 13,
    parameter int HYST_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [TEMP_W-1:0] temp_i,
    input logic [TEMP_W-1:0] upper_lim_i,
    input logic [TEMP_W-1:0] lower_lim_i,
    input logic [TEMP_W-1:0] crit_lim_i,
    input logic [HYST_W-1:0] crit_hyst_i,
    input logic [1:0]        mode_i,
    input logic              event_en_i,
    input logic              clear_evt_i,
    input logic              event_drive_o,
    input logic              flag_above_upper_o,
    input logic              flag_below_lower_o,
    input logic              flag_above_crit_o,
    input logic              win_latch
);
    localparam int EXT_W = TEMP_W + 1;

    logic signed [EXT_W-1:0] t_x;
    logic signed [EXT_W-1:0] rel_x;
    logic gt_hi, lt_lo, gt_cr, ge_rel;

    assign t_x    = $signed({temp_i[TEMP_W-1], temp_i});
    assign rel_x  = $signed({crit_lim_i[TEMP_W-1], crit_lim_i})
                  - $signed({{(EXT_W-HYST_W){1'b0}}, crit_hyst_i});
    assign gt_hi  = $signed(temp_i) > $signed(upper_lim_i);
    assign lt_lo  = $signed(temp_i) < $signed(lower_lim_i);
    assign gt_cr  = $signed(temp_i) > $signed(crit_lim_i);
    assign ge_rel = t_x >= rel_x;

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        $past(rst_i) |-> !event_drive_o && !flag_above_upper_o
                         && !flag_below_lower_o && !flag_above_crit_o);

    assert_flags_track_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> flag_above_upper_o == $past(gt_hi)
                          && flag_below_lower_o == $past(lt_lo)
                          && flag_above_crit_o == $past(gt_cr));

    assert_follow_drives_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $past(mode_i) == 2'd1 && $past(event_en_i)
        && $past(gt_hi || lt_lo) |-> event_drive_o);

    assert_latch_holds_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        win_latch && !clear_evt_i && mode_i == 2'd0 |=> win_latch);

    assert_crit_drives_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $past(event_en_i) && $past(gt_cr) |-> event_drive_o);

    assert_crit_only_release_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $past(mode_i) == 2'd2 && event_drive_o |-> $past(ge_rel));

    assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && !$past(event_en_i) |-> !event_drive_o);

    assert_alt_follow_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && $past(mode_i) == 2'd3 && $past(event_en_i)
        && $past(gt_hi || lt_lo) |-> event_drive_o);

    assert_latch_mode_only_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) && win_latch |-> $past(mode_i) == 2'd0);

endmodule

bind tev_ctrl tev_ctrl_chk #(.TEMP_W(TEMP_W), .HYST_W(HYST_W)) u_chk (
    .clk_i              (clk_i),
    .rst_i              (rst_i),
    .temp_i             (temp_i),
    .upper_lim_i        (upper_lim_i),
    .lower_lim_i        (lower_lim_i),
    .crit_lim_i         (crit_lim_i),
    .crit_hyst_i        (crit_hyst_i),
    .mode_i             (mode_i),
    .event_en_i         (event_en_i),
    .clear_evt_i        (clear_evt_i),
    .event_drive_o      (event_drive_o),
    .flag_above_upper_o (flag_above_upper_o),
    .flag_below_lower_o (flag_below_lower_o),
    .flag_above_crit_o  (flag_above_crit_o),
    .win_latch          (win_latch)
);

// File: tb/sim_tev_ctrl.sv
module sim_tev_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 13;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] temp = '0, hi = '0, lo = '0, crit = '0;
    logic [HW-1:0] hyst = '0;
    logic [1:0]    mode = 2'd0;
    logic          en = 1'b0, clr = 1'b0;
    logic          drive, f_hi, f_lo, f_cr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    int  m_hi, m_lo, m_cr, m_hy;
    bit  m_prev, m_latch, m_crit;

    always #(CLK_PERIOD/2) clk = ~clk;

    tev_ctrl #(.TEMP_W(TW), .HYST_W(HW)) u0 (
        .clk_i(clk), .rst_i(rst), .temp_i(temp), .upper_lim_i(hi),
        .lower_lim_i(lo), .crit_lim_i(crit), .crit_hyst_i(hyst),
        .mode_i(mode), .event_en_i(en), .clear_evt_i(clr),
        .event_drive_o(drive), .flag_above_upper_o(f_hi),
        .flag_below_lower_o(f_lo), .flag_above_crit_o(f_cr)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic set_limits(input int h, input int l, input int c, input int y);
        m_hi = h; m_lo = l; m_cr = c; m_hy = y;
        hi = TW'(h); lo = TW'(l); crit = TW'(c); hyst = HW'(y);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        temp = TW'(500); en = 1'b1; mode = 2'd1; clr = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R1 drive", drive, 1'b0);
        chk("R1 upper", f_hi, 1'b0);
        chk("R1 lower", f_lo, 1'b0);
        chk("R1 crit", f_cr, 1'b0);
        m_prev = 0; m_latch = 0; m_crit = 0;
        rst = 1'b0;
    endtask

    // one model-checked step; called at a negative edge
    task automatic step(input int t, input int md, input bit e, input bit c);
        bit cond, rise, win, x_drive;
        string rq;
        temp = TW'(t); mode = 2'(md); en = e; clr = c;
        @(posedge clk);
        cond = (t > m_hi) || (t < m_lo);
        if (t > m_cr) m_crit = 1;
        else if (t < m_cr - m_hy) m_crit = 0;
        rise = cond && !m_prev;
        if (md == 0) m_latch = rise || (m_latch && !c);
        else m_latch = 0;
        m_prev = cond;
        win = (md == 0) ? m_latch : (md == 2) ? 1'b0 : cond;
        x_drive = e && (win || m_crit);
        @(negedge clk);
        chk((t < 0) ? "R9 upper" : "R2 upper", f_hi, t > m_hi);
        chk((t < 0) ? "R9 lower" : "R2 lower", f_lo, t < m_lo);
        chk("R2 crit", f_cr, t > m_cr);
        if (!e)            rq = "R8 drive";
        else if (m_crit)   rq = "R6 drive";
        else if (md == 0)  rq = "R4 drive";
        else if (md == 1)  rq = "R3 drive";
        else if (md == 2)  rq = "R7 drive";
        else               rq = "R10 drive";
        chk(rq, drive, x_drive);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int t;
        logic [15:0] lf;
        int md;
        bit e;
        set_limits(20, -20, 40, 8);
        @(negedge clk);
        do_reset();

        // directed: latch, clear while holding, re-arm (R4, R5)
        set_limits(20, -20, 100, 4);
        step(0, 0, 1, 0);   chk("R4 idle", drive, 1'b0);
        step(30, 0, 1, 0);  chk("R4 set", drive, 1'b1);
        step(5, 0, 1, 0);   chk("R4 held inside window", drive, 1'b1);
        step(31, 0, 1, 0);  chk("R4 still held", drive, 1'b1);
        step(32, 0, 1, 1);  chk("R5 clear while above", drive, 1'b0);
        step(33, 0, 1, 0);  chk("R5 no re-set without crossing", drive, 1'b0);
        step(0, 0, 1, 0);   chk("R5 back inside", drive, 1'b0);
        step(-25, 0, 1, 1); chk("R5 crossing beats clear", drive, 1'b1);
        step(-25, 0, 0, 0); chk("R8 disabled hides latch", drive, 1'b0);
        step(-25, 0, 1, 0); chk("R8 re-enable shows latch", drive, 1'b1);

        // directed: hysteresis band approached both ways (R6)
        set_limits(200, -200, 40, 8);
        step(40, 2, 1, 0);  chk("R6 equal not above", drive, 1'b0);
        step(41, 2, 1, 0);  chk("R6 above sets", drive, 1'b1);
        step(32, 2, 1, 0);  chk("R6 at release holds", drive, 1'b1);
        step(31, 2, 1, 1);  chk("R6 below release drops", drive, 1'b0);
        step(35, 2, 1, 0);  chk("R6 band from below stays off", drive, 1'b0);
        step(41, 0, 1, 1);  chk("R6 clear ignored", drive, 1'b1);

        // sweeps: limit sets x modes x enable, ramp up then down
        for (int ls = 0; ls < 3; ls++) begin
            case (ls)
                0: set_limits(20, -20, 40, 8);
                1: set_limits(-10, -50, 0, 0);
                default: set_limits(60, 30, -5, 255);
            endcase
            for (int m = 0; m < 4; m++) begin
                for (int ee = 0; ee < 2; ee++) begin
                    for (int k = -80; k <= 80; k++)
                        step(k, m, ee[0], (m == 0) && ((k % 5) == 0));
                    for (int k = 80; k >= -80; k--)
                        step(k, m, ee[0], (m == 0) && ((k % 7) == 0));
                end
            end
        end

        // extreme limits: release threshold below the representable range (R9)
        set_limits(4095, -4096, -4096, 255);
        step(-4096, 1, 1, 0);
        step(-4095, 1, 1, 0);
        step(-4096, 1, 1, 0);

        // random walk with mode changes
        set_limits(25, -15, 45, 6);
        lf = 16'hACE1; t = 0; md = 0; e = 1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            t = t + int'(lf[2:0] % 3'd7) - 3;
            if (t > 90) t = 90;
            if (t < -60) t = -60;
            if ((i % 97) == 0) md = int'(lf[6:5]);
            if ((i % 61) == 0) e = lf[8] | lf[9];
            step(t, md, e, lf[11:8] == 4'h0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule